// File: doc/BRIEF.md
# Capture/Compare Timer with Input Filter

This block is a 16-bit up-counter with two uses. In input capture mode, a rising edge on an external input records the current count and sets a sticky flag. In output compare mode, two compare registers are matched against the count. On each match, a per-channel action updates a single output pin. The action can be hold, invert, force low or force high. The counter can also be cleared whenever compare 1 matches, which gives it a programmable period.

The capture input first passes through a two-flop synchronizer and then a digital noise filter. The filter can be bypassed. Otherwise it samples on one of three externally supplied rate strobes and accepts a new level only after three equal samples in a row. Software uses a small register port with combinational read-back. It reaches control, count, both compare values, the capture value and the capture flag. The counter advances on an external count enable while the run bit is set.

Register addresses:

| Address | Contents | Access |
|---|---|---|
| 0 | Control | read/write |
| 1 | Count | read-only |
| 2 | Compare 0 | read/write |
| 3 | Compare 1 | read/write |
| 4 | Capture value | read-only |
| 5 | Status; bit 0 is the capture flag | write 1 to clear |

Control fields:

| Bits | Field | Encoding |
|---|---|---|
| 0 | Run | 1 = counting |
| 2:1 | Filter select | 00 bypass, 01 rate-1 strobe, 10 rate-8 strobe, 11 rate-32 strobe |
| 3 | Mode | 0 = capture, 1 = compare |
| 4 | Reload | 1 = clear the counter on a compare 1 match |
| 6:5 | Compare 0 action | see below |
| 8:7 | Compare 1 action | see below |

Compare action codes: 00 hold, 01 invert, 10 low, 11 high.

Top module: `cc_timer`

## Requirements
- R1: After reset, the following all read zero: control, count, capture value and status. The compare output is low.
- R2: With run=1, the count rises by one on each clock where the count enable is high. With reload=0 it wraps from FFFFh to 0000h. The count stays unchanged when the count enable is low or run=0.
- R3: In compare mode with reload=1, a counting clock at which the count equals compare 1 loads 0000h instead of incrementing.
- R4: On a compare match, the output applies that channel's action: 00 hold, 01 invert, 10 low, 11 high.
- R5: When both channels match in the same clock, the compare 1 action is applied after the compare 0 action and sets the final level.
- R6: The compare output keeps its level while run=0, and while the block is in capture mode.
- R7: A write to the control register leaves the mode bit unchanged if run was 1 before that write.
- R8: While mode=0, the reload bit and both action fields read zero, and they cause no reload and no output change.
- R9: In capture mode, a rising edge of the filtered input copies the count into the capture register and sets status bit 0. Writing 1 to status bit 0 clears the flag. Writing 0 does not clear it, and a falling edge captures nothing.
- R10: With filter select 00, the synchronized input is used directly, so a one-clock input pulse is captured.
- R11: With filtering on, the filtered level changes only after three consecutive strobe samples of the same raw level. A level seen on only two samples is rejected.
- R12: When filtering is on, only the strobe chosen by filter select causes sampling. Pulses on the other two strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| cnt_en | input | 1 | Count enable |
| stb_f1 | input | 1 | Rate-1 filter sampling strobe |
| stb_f8 | input | 1 | Rate-8 filter sampling strobe |
| stb_f32 | input | 1 | Rate-32 filter sampling strobe |
| cap_in | input | 1 | External capture input |
| cmp_out | output | 1 | Compare output pin |

## Verification
The wrap test runs the counter from FFFFh to 0000h. A counter with an off-by-one width, or with a spurious reload while reload is off, would read a wrong count there. The reload test checks the exact period of compare 1 plus one, and a simultaneous match of both channels with opposite actions. A design that applied compare 0 last, or that reloaded one count late, would leave the wrong pin level or count. The lock test writes the mode bit while running and writes action fields in capture mode. A design that failed to lock the mode or clear those fields would read back different control values, or would move the pin. The filter tests send a two-sample glitch, and they pulse the strobes that are not selected. A filter that needed fewer samples, or that obeyed the wrong strobe, would set the capture flag.

// File: rtl/cct_pkg.sv
package cct_pkg;

  localparam int CTRL_W = 9;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } cmp_act_e;

  typedef enum logic [1:0] {
    FSEL_OFF = 2'b00,
    FSEL_F1  = 2'b01,
    FSEL_F8  = 2'b10,
    FSEL_F32 = 2'b11
  } fsel_e;

  // packed MSB first: act1[8:7] act0[6:5] reload[4] cmp_mode[3] fsel[2:1] run[0]
  typedef struct packed {
    cmp_act_e act1;
    cmp_act_e act0;
    logic     reload;
    logic     cmp_mode;
    fsel_e    fsel;
    logic     run;
  } ctrl_t;

  function automatic logic act_apply(input logic lvl, input cmp_act_e act);
    case (act)
      ACT_TOGGLE: return ~lvl;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return lvl;
    endcase
  endfunction

endpackage

// File: rtl/cct_regs.sv
module cct_regs
  import cct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cmp0_val,
  output logic [CNT_W-1:0]  cmp1_val
);

  ctrl_t wr_ctrl;
  ctrl_t ctrl_nxt;

  assign wr_ctrl = ctrl_t'(wdata[CTRL_W-1:0]);

  always_comb begin
    ctrl_nxt = wr_ctrl;
    ctrl_nxt.cmp_mode = ctrl.run ? ctrl.cmp_mode : wr_ctrl.cmp_mode;
    if (!ctrl_nxt.cmp_mode) begin
      ctrl_nxt.reload = 1'b0;
      ctrl_nxt.act0   = ACT_HOLD;
      ctrl_nxt.act1   = ACT_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      cmp0_val <= '0;
      cmp1_val <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: ctrl     <= ctrl_nxt;
        A_CMP0: cmp0_val <= wdata;
        A_CMP1: cmp1_val <= wdata;
        default: ;
      endcase
    end
  end

  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.run |=> $stable(ctrl.cmp_mode));

  assert_capture_fields_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.cmp_mode |-> (!ctrl.reload && ctrl.act0 == ACT_HOLD && ctrl.act1 == ACT_HOLD));

endmodule

// File: rtl/cct_filter.sv
module cct_filter
  import cct_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  raw,
  input  fsel_e fsel,
  input  logic  stb_f1,
  input  logic  stb_f8,
  input  logic  stb_f32,
  output logic  filt
);

  logic [SYNC_LEN-1:0] sync_q;
  logic                synced;
  logic                stb_sel;
  logic [FILT_LEN-1:0] hist_q;
  logic [FILT_LEN-1:0] hist_nxt;
  logic                agree;
  logic                level_q;

  for (genvar i = 0; i < SYNC_LEN; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= (i == 0) ? raw : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  assign synced = sync_q[SYNC_LEN-1];

  always_comb begin
    case (fsel)
      FSEL_F1:  stb_sel = stb_f1;
      FSEL_F8:  stb_sel = stb_f8;
      FSEL_F32: stb_sel = stb_f32;
      default:  stb_sel = 1'b0;
    endcase
  end

  assign hist_nxt = {hist_q[FILT_LEN-2:0], synced};
  assign agree    = (hist_nxt == '0) || (hist_nxt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      level_q <= 1'b0;
    end else if (stb_sel) begin
      hist_q <= hist_nxt;
      if (agree) level_q <= hist_nxt[0];
    end
  end

  assign filt = (fsel == FSEL_OFF) ? synced : level_q;

  assert_filter_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel != FSEL_OFF && !stb_sel) |=> $stable(level_q));

  assert_filter_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_sel && (hist_q[FILT_LEN-2:0] != {(FILT_LEN-1){synced}})) |=> $stable(level_q));

endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_en,
  input  logic             reload_on,
  input  logic [CNT_W-1:0] cmp0_val,
  input  logic [CNT_W-1:0] cmp1_val,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             hit0,
  output logic             hit1,
  output logic             clr
);

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                   input logic do_clr);
    return do_clr ? '0 : c + CNT_W'(1);
  endfunction

  assign tick = run & cnt_en;
  assign hit0 = tick && (count == cmp0_val);
  assign hit1 = tick && (count == cmp1_val);
  assign clr  = hit1 & reload_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count_next(count, clr);
  end

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (count - $past(count)) == CNT_W'(1));

  assert_reload_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              cnt_en,
  input  logic              stb_f1,
  input  logic              stb_f8,
  input  logic              stb_f32,
  input  logic              cap_in,
  output logic              cmp_out
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp0_val;
  logic [CNT_W-1:0] cmp1_val;
  logic [CNT_W-1:0] count;
  logic             tick;
  logic             hit0;
  logic             hit1;
  logic             clr;
  logic             filt;
  logic             filt_d;
  logic             cap_rise;
  logic [CNT_W-1:0] cap_q;
  logic             cap_flag;
  logic             cmp_nxt;
  logic             flag_clr;

  cct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ctrl     (ctrl),
    .cmp0_val (cmp0_val),
    .cmp1_val (cmp1_val)
  );

  cct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl.run),
    .cnt_en    (cnt_en),
    .reload_on (ctrl.reload & ctrl.cmp_mode),
    .cmp0_val  (cmp0_val),
    .cmp1_val  (cmp1_val),
    .count     (count),
    .tick      (tick),
    .hit0      (hit0),
    .hit1      (hit1),
    .clr       (clr)
  );

  cct_filter #(.SYNC_LEN(2), .FILT_LEN(3)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (cap_in),
    .fsel    (ctrl.fsel),
    .stb_f1  (stb_f1),
    .stb_f8  (stb_f8),
    .stb_f32 (stb_f32),
    .filt    (filt)
  );

  // compare 0 applied first, compare 1 last
  always_comb begin
    cmp_nxt = cmp_out;
    if (ctrl.cmp_mode) begin
      if (hit0) cmp_nxt = act_apply(cmp_nxt, ctrl.act0);
      if (hit1) cmp_nxt = act_apply(cmp_nxt, ctrl.act1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_out <= 1'b0;
    else        cmp_out <= cmp_nxt;
  end

  assign cap_rise = filt & ~filt_d & ~ctrl.cmp_mode;
  assign flag_clr = wr_en && (addr == A_STAT) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_d   <= 1'b0;
      cap_q    <= '0;
      cap_flag <= 1'b0;
    end else begin
      filt_d <= filt;
      if (cap_rise) begin
        cap_q    <= count;
        cap_flag <= 1'b1;
      end else if (flag_clr) begin
        cap_flag <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
      A_CNT:   rdata = count;
      A_CMP0:  rdata = cmp0_val;
      A_CMP1:  rdata = cmp1_val;
      A_CAP:   rdata = cap_q;
      A_STAT:  rdata = {{(CNT_W-1){1'b0}}, cap_flag};
      default: rdata = '0;
    endcase
  end

  assert_both_hit_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && hit1 && ctrl.cmp_mode && ctrl.act1 == ACT_HIGH) |=> cmp_out);

  assert_both_hit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && hit1 && ctrl.cmp_mode && ctrl.act1 == ACT_LOW) |=> !cmp_out);

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run || !ctrl.cmp_mode) |=> $stable(cmp_out));

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> (cap_flag && cap_q == $past(count)));

endmodule

// File: tb/sim_cc_timer.sv
module sim_cc_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cnt_en = 1'b0;
  logic        stb_f1 = 1'b0;
  logic        stb_f8 = 1'b0;
  logic        stb_f32 = 1'b0;
  logic        cap_in = 1'b0;
  logic        cmp_out;

  int total = 0;
  int bad = 0;

  localparam logic [1:0] HOLD = 2'b00, TOG = 2'b01, LOW = 2'b10, HIGH = 2'b11;

  always #10 clk = ~clk;

  cc_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_en(cnt_en), .stb_f1(stb_f1), .stb_f8(stb_f8),
    .stb_f32(stb_f32), .cap_in(cap_in), .cmp_out(cmp_out)
  );

  function automatic logic [15:0] cw(input logic run, input logic [1:0] fs,
                                     input logic mode, input logic rel,
                                     input logic [1:0] a0, input logic [1:0] a1);
    return {7'b0, a1, a0, rel, mode, fs, run};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; cnt_en = 1'b0; cap_in = 1'b0;
    stb_f1 = 1'b0; stb_f8 = 1'b0; stb_f32 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      if (which == 1) stb_f1 = 1'b1;
      else if (which == 8) stb_f8 = 1'b1;
      else stb_f32 = 1'b1;
      @(negedge clk);
      stb_f1 = 1'b0; stb_f8 = 1'b0; stb_f32 = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(3'd0, v); chk("R1", "ctrl", v, 16'h0000);
    rd(3'd1, v); chk("R1", "count", v, 16'h0000);
    rd(3'd4, v); chk("R1", "capture", v, 16'h0000);
    rd(3'd5, v); chk("R1", "status", v, 16'h0000);
    chk("R1", "cmp_out", {15'b0, cmp_out}, 16'h0000);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    do_reset();
    wr(3'd0, cw(1, 2'b00, 0, 0, HOLD, HOLD));
    ticks(65535);
    rd(3'd1, v); chk("R2", "count at top", v, 16'hFFFF);
    ticks(1);
    rd(3'd1, v); chk("R2", "count wrapped", v, 16'h0000);
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk("R2", "count idle enable low", v, 16'h0000);
    ticks(3);
    rd(3'd1, v); chk("R2", "count three ticks", v, 16'h0003);
    wr(3'd0, cw(0, 2'b00, 0, 0, HOLD, HOLD));
    ticks(4);
    rd(3'd1, v); chk("R2", "count stopped", v, 16'h0003);
  endtask

  task automatic t_reload_toggle();
    logic [15:0] v;
    do_reset();
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd7);
    wr(3'd0, cw(1, 2'b00, 1, 1, TOG, HOLD));
    ticks(8);
    rd(3'd1, v); chk("R3", "count after period", v, 16'h0000);
    chk("R4", "toggle once", {15'b0, cmp_out}, 16'h0001);
    ticks(8);
    rd(3'd1, v); chk("R3", "count after second period", v, 16'h0000);
    chk("R4", "toggle twice", {15'b0, cmp_out}, 16'h0000);
    ticks(8);
    chk("R4", "toggle thrice", {15'b0, cmp_out}, 16'h0001);
    wr(3'd0, cw(1, 2'b00, 1, 1, HOLD, HOLD));
    ticks(8);
    chk("R4", "hold action", {15'b0, cmp_out}, 16'h0001);
  endtask

  task automatic t_set_clear();
    logic [15:0] v;
    do_reset();
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd10);
    wr(3'd0, cw(1, 2'b00, 1, 0, HIGH, LOW));
    ticks(5);
    chk("R4", "before match0", {15'b0, cmp_out}, 16'h0000);
    ticks(1);
    chk("R4", "drive high on match0", {15'b0, cmp_out}, 16'h0001);
    ticks(5);
    chk("R4", "drive low on match1", {15'b0, cmp_out}, 16'h0000);
    rd(3'd1, v); chk("R4", "free count", v, 16'd11);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd4);
    wr(3'd0, cw(1, 2'b00, 1, 1, LOW, HIGH));
    ticks(5);
    chk("R5", "cmp1 high wins", {15'b0, cmp_out}, 16'h0001);
    wr(3'd0, cw(1, 2'b00, 1, 1, HIGH, LOW));
    ticks(5);
    chk("R5", "cmp1 low wins", {15'b0, cmp_out}, 16'h0000);
  endtask

  task automatic t_stop_hold();
    logic [15:0] v;
    do_reset();
    wr(3'd2, 16'd2);
    wr(3'd0, cw(1, 2'b00, 1, 0, HIGH, HOLD));
    ticks(3);
    chk("R6", "set high", {15'b0, cmp_out}, 16'h0001);
    wr(3'd0, cw(0, 2'b00, 1, 0, LOW, HOLD));
    wr(3'd2, 16'd3);
    ticks(5);
    chk("R6", "held while stopped", {15'b0, cmp_out}, 16'h0001);
    rd(3'd1, v); chk("R6", "count frozen", v, 16'd3);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    do_reset();
    wr(3'd0, cw(1, 2'b00, 1, 0, HOLD, HOLD));
    wr(3'd0, cw(1, 2'b00, 0, 0, HOLD, HOLD));
    rd(3'd0, v); chk("R7", "mode kept while running", v, 16'h0009);
    wr(3'd0, cw(0, 2'b00, 0, 0, HOLD, HOLD));
    rd(3'd0, v); chk("R7", "mode kept on stopping write", v, 16'h0008);
    wr(3'd0, cw(0, 2'b00, 0, 1, HIGH, HIGH));
    rd(3'd0, v); chk("R8", "fields forced zero", v, 16'h0000);
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd2);
    wr(3'd0, cw(1, 2'b00, 0, 1, HIGH, HIGH));
    rd(3'd0, v); chk("R8", "run only", v, 16'h0001);
    ticks(5);
    chk("R8", "no pin action in capture", {15'b0, cmp_out}, 16'h0000);
    rd(3'd1, v); chk("R8", "no reload in capture", v, 16'd5);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    do_reset();
    wr(3'd0, cw(1, 2'b00, 0, 0, HOLD, HOLD));
    ticks(20);
    cap_in = 1'b1;
    @(negedge clk);
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R10", "bypass capture value", v, 16'd20);
    rd(3'd5, v); chk("R9", "flag set", v, 16'h0001);
    wr(3'd5, 16'h0000);
    rd(3'd5, v); chk("R9", "write 0 keeps flag", v, 16'h0001);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); chk("R9", "flag cleared", v, 16'h0000);
    ticks(5);
    cap_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R9", "second capture", v, 16'd25);
    wr(3'd5, 16'h0001);
    cap_in = 1'b0;
    repeat (5) @(negedge clk);
    rd(3'd5, v); chk("R9", "falling edge no capture", v, 16'h0000);
  endtask

  task automatic t_filter();
    logic [15:0] v;
    do_reset();
    wr(3'd0, cw(1, 2'b01, 0, 0, HOLD, HOLD));
    ticks(9);
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1, 2);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
    pulse(1, 3);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R11", "two-sample glitch rejected", v, 16'h0000);
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1, 2);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R11", "two samples not enough", v, 16'h0000);
    pulse(1, 1);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R11", "third sample accepts", v, 16'h0001);
    rd(3'd4, v); chk("R11", "filtered capture value", v, 16'd9);
  endtask

  task automatic t_rate();
    logic [15:0] v;
    do_reset();
    wr(3'd0, cw(1, 2'b10, 0, 0, HOLD, HOLD));
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1, 4);
    pulse(32, 4);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R12", "other strobes ignored", v, 16'h0000);
    pulse(8, 3);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R12", "selected strobe accepts", v, 16'h0001);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wrap();
    t_reload_toggle();
    t_set_clear();
    t_same_cycle();
    t_stop_hold();
    t_lock();
    t_capture();
    t_filter();
    t_rate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule